// File: doc/BRIEF.md
# Pipeline Error Rollback Arbiter

This block is the recovery controller for a five-stage in-order pipeline whose inter-stage registers carry error-correcting codes. Each cycle every stage reports whether its decoder saw an uncorrectable word, and the execute stage reports whether a control transfer (branch or jump) is taking effect. From these flags the arbiter decides, one cycle later, which single stage replays its saved one-cycle snapshot. It also decides which stages discard their contents, whether the whole pipeline stalls for the replay cycle, and whether the fault keeps recurring so often that the core must restart from address 0.

Errors in the two front stages are moot when execute redirects the fetch stream, so they are only flushed. When several stages fail together, the stage nearest the front of the pipeline wins the replay and the other failing stages are flushed. A saturating run-length counter per stage turns a persistent fault into a single-cycle core reset request. The replay registers and the datapath sit outside this block.

Top module: `rollback_arbiter`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it rises, `redo`, `flush`, `stall` and `core_reset` are all zero.
- R2: Bit i of `stage_err`, `redo` and `flush` refers to stage i+1: bit 0 fetch, bit 1 decode, bit 2 execute, bit 3 memory, bit 4 write-back. A lone error in bit 2, 3 or 4 yields, in the next cycle, `redo` with only that bit set, `stall` high and `flush` zero, whatever `ctl_xfer` is.
- R3: With `ctl_xfer` high, errors in bits 0 and 1 cause no replay and no stall; the next cycle shows those bits in `flush`.
- R4: With `ctl_xfer` low, a lone error in bit 0 or 1 is replayed like R2.
- R5: When several replayable errors arrive in one cycle, the lowest-numbered one is replayed and every other erroring stage is flushed in the same response cycle.
- R6: Every decision lasts exactly one cycle: `redo`, `flush` and `stall` reflect the inputs of the previous cycle only, and `stall` is high exactly when `redo` is nonzero.
- R7: A stage's repeat count rises in each cycle its error bit is set and clears in any cycle it is clear. An error arriving when the count already equals `REPEAT_LIMIT` (default 2) gives, in the next cycle, `core_reset` high with `redo`, `flush` and `stall` low. With the default, three consecutive error cycles in one stage request the reset.
- R8: `core_reset` lasts one cycle. The inputs seen during that cycle are ignored and produce all-zero outputs the cycle after. All repeat counts restart from zero, both after the reset request and after `rst_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| stage_err | input | NUM_STAGES | Per-stage uncorrectable decode error, bit 0 = fetch |
| ctl_xfer | input | 1 | A control transfer is taking effect in execute |
| redo | output | NUM_STAGES | One-hot replay strobe for the chosen stage |
| flush | output | NUM_STAGES | Per-stage discard strobe |
| stall | output | 1 | Whole-pipeline hold during the replay cycle |
| core_reset | output | 1 | Single-cycle request to restart the core at address 0 |

States: `ST_RUN` (no action), `ST_REDO` (a replay is issued, stall high), `ST_DROP` (only flushes issued), `ST_FATAL` (reset request). Transitions: any non-fatal state goes to `ST_FATAL` on a repeat-limit hit, else to `ST_REDO` on a replayable error, else to `ST_DROP` on jump-masked errors only, else to `ST_RUN`. `ST_FATAL` always returns to `ST_RUN`.

## Verification
The hardest condition to reach from the ports is the repeat-limit escalation: random error flags rarely persist in one stage for three straight cycles, and any clean cycle in between resets the run. The stimulus therefore holds a chosen stage's error bit for several cycles in directed bursts, checks that a gap breaks the run, and checks that the cycle after the reset request ignores its inputs. Mixed random traffic then runs with a raised per-stage error rate so that simultaneous errors, jump masking and occasional escalations all appear under a reference model.

// File: rtl/rb_arbiter_pkg.sv
package rb_arbiter_pkg;
    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_REDO  = 2'd1,
        ST_DROP  = 2'd2,
        ST_FATAL = 2'd3
    } rb_state_e;

    // number of front stages whose errors a taken control transfer makes moot
    localparam int unsigned EARLY_STAGES = 2;
endpackage

// File: rtl/rb_repeat_ctr.sv
module rb_repeat_ctr #(
    parameter int unsigned REPEAT_LIMIT = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic err,
    output logic at_limit
);
    localparam int unsigned CNT_W = $clog2(REPEAT_LIMIT + 2);
    localparam logic [CNT_W-1:0] LIMIT_V = CNT_W'(REPEAT_LIMIT);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr || !err) begin
            cnt_q <= '0;
        end else if (cnt_q < LIMIT_V) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign at_limit = (cnt_q >= LIMIT_V);
endmodule

// File: rtl/rb_prio_pick.sv
module rb_prio_pick #(
    parameter int unsigned WIDTH = 5
) (
    input  logic [WIDTH-1:0] req,
    output logic [WIDTH-1:0] win
);
    logic [WIDTH:0] seen;

    assign seen[0] = 1'b0;

    for (genvar i = 0; i < WIDTH; i++) begin : g_pick
        assign win[i]    = req[i] & ~seen[i];
        assign seen[i+1] = seen[i] | req[i];
    end
endmodule

// File: rtl/rollback_arbiter.sv
module rollback_arbiter
    import rb_arbiter_pkg::*;
#(
    parameter int unsigned NUM_STAGES   = 5,
    parameter int unsigned REPEAT_LIMIT = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_STAGES-1:0] stage_err,
    input  logic                  ctl_xfer,
    output logic [NUM_STAGES-1:0] redo,
    output logic [NUM_STAGES-1:0] flush,
    output logic                  stall,
    output logic                  core_reset
);
    localparam logic [NUM_STAGES-1:0] EARLY_MASK =
        NUM_STAGES'((1 << EARLY_STAGES) - 1);

    rb_state_e             state_q, state_d;
    logic [NUM_STAGES-1:0] redo_q, flush_q;
    logic [NUM_STAGES-1:0] redo_d, flush_d;
    logic [NUM_STAGES-1:0] moot_mask, dropped, live, winner, at_limit;
    logic                  fatal_hit, ctr_clr;

    assign moot_mask = ctl_xfer ? EARLY_MASK : '0;
    assign dropped   = stage_err & moot_mask;
    assign live      = stage_err & ~moot_mask;
    assign fatal_hit = (state_q != ST_FATAL) && |(stage_err & at_limit);
    assign ctr_clr   = fatal_hit || (state_q == ST_FATAL);

    for (genvar s = 0; s < NUM_STAGES; s++) begin : g_ctr
        rb_repeat_ctr #(.REPEAT_LIMIT(REPEAT_LIMIT)) u_ctr (
            .clk      (clk),
            .rst_n    (rst_n),
            .clr      (ctr_clr),
            .err      (stage_err[s]),
            .at_limit (at_limit[s])
        );
    end

    rb_prio_pick #(.WIDTH(NUM_STAGES)) u_pick (
        .req (live),
        .win (winner)
    );

    // next-state and next-output decision
    always_comb begin
        state_d = ST_RUN;
        redo_d  = '0;
        flush_d = '0;
        unique case (state_q)
            ST_FATAL: begin
                state_d = ST_RUN;
            end
            ST_RUN, ST_REDO, ST_DROP: begin
                if (fatal_hit) begin
                    state_d = ST_FATAL;
                end else if (|live) begin
                    state_d = ST_REDO;
                    redo_d  = winner;
                    flush_d = (live & ~winner) | dropped;
                end else if (|dropped) begin
                    state_d = ST_DROP;
                    flush_d = dropped;
                end else begin
                    state_d = ST_RUN;
                end
            end
            default: state_d = ST_RUN;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
        end else begin
            state_q <= state_d;
        end
    end

    // registered strobes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            redo_q  <= '0;
            flush_q <= '0;
        end else begin
            redo_q  <= redo_d;
            flush_q <= flush_d;
        end
    end

    assign redo       = redo_q;
    assign flush      = flush_q;
    assign stall      = (state_q == ST_REDO);
    assign core_reset = (state_q == ST_FATAL);
endmodule

// File: rtl/rb_arbiter_chk.sv
module rb_arbiter_chk #(
    parameter int unsigned NUM_STAGES = 5
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [NUM_STAGES-1:0] stage_err,
    input logic                  ctl_xfer,
    input logic [NUM_STAGES-1:0] redo,
    input logic [NUM_STAGES-1:0] flush,
    input logic                  stall,
    input logic                  core_reset
);
    // R5
    redo_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(redo));

    // R5
    redo_flush_apart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (redo & flush) == '0);

    // R6
    stall_with_redo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall == (redo != '0));

    // R8
    reset_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        core_reset |=> !core_reset && redo == '0 && flush == '0);

    // R7
    reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        core_reset |-> redo == '0 && flush == '0 && !stall);

    // R3
    moot_no_redo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_xfer && stage_err[NUM_STAGES-1:2] == '0) |=> redo == '0);

    // R4
    fetch_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stage_err[0] && !ctl_xfer && !core_reset) |=> (redo[0] || core_reset));
endmodule

bind rollback_arbiter rb_arbiter_chk #(.NUM_STAGES(NUM_STAGES)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .stage_err  (stage_err),
    .ctl_xfer   (ctl_xfer),
    .redo       (redo),
    .flush      (flush),
    .stall      (stall),
    .core_reset (core_reset)
);

// File: tb/rollback_arbiter_tb.sv
`timescale 1ns/1ps
module rollback_arbiter_tb;
    localparam int NS    = 5;
    localparam int LIMIT = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NS-1:0] stage_err = '0;
    logic          ctl_xfer = 1'b0;
    logic [NS-1:0] redo, flush;
    logic          stall, core_reset;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // reference model state
    int m_cnt [NS];
    bit m_fatal;
    logic [NS-1:0] e_redo, e_flush;
    logic          e_stall, e_reset;

    always #2.5 clk = ~clk;

    rollback_arbiter #(.NUM_STAGES(NS), .REPEAT_LIMIT(LIMIT)) u_dut (
        .clk(clk), .rst_n(rst_n), .stage_err(stage_err), .ctl_xfer(ctl_xfer),
        .redo(redo), .flush(flush), .stall(stall), .core_reset(core_reset)
    );

    function automatic logic [NS-1:0] lowest(input logic [NS-1:0] v);
        for (int i = 0; i < NS; i++) if (v[i]) return NS'(1) << i;
        return '0;
    endfunction

    task automatic model_reset();
        for (int i = 0; i < NS; i++) m_cnt[i] = 0;
        m_fatal = 1'b0;
        e_redo = '0; e_flush = '0; e_stall = 1'b0; e_reset = 1'b0;
    endtask

    // advance the model by one clock edge with the given inputs
    task automatic model_step(input logic [NS-1:0] e, input logic j);
        logic [NS-1:0] mask, live, drop, w;
        bit hit;
        e_redo = '0; e_flush = '0; e_stall = 1'b0; e_reset = 1'b0;
        if (m_fatal) begin
            for (int i = 0; i < NS; i++) m_cnt[i] = 0;
            m_fatal = 1'b0;
            return;
        end
        hit = 1'b0;
        for (int i = 0; i < NS; i++) if (e[i] && m_cnt[i] >= LIMIT) hit = 1'b1;
        if (hit) begin
            for (int i = 0; i < NS; i++) m_cnt[i] = 0;
            m_fatal = 1'b1;
            e_reset = 1'b1;
            return;
        end
        for (int i = 0; i < NS; i++) m_cnt[i] = e[i] ? ((m_cnt[i] < LIMIT) ? m_cnt[i] + 1 : m_cnt[i]) : 0;
        mask = j ? NS'(3) : '0;
        live = e & ~mask;
        drop = e & mask;
        w = lowest(live);
        e_redo  = w;
        e_flush = (live & ~w) | drop;
        e_stall = (w != '0);
    endtask

    task automatic check_out(input string tag);
        checks++;
        if (redo !== e_redo || flush !== e_flush || stall !== e_stall || core_reset !== e_reset) begin
            fails++;
            $display("FAIL %s: redo=%b flush=%b stall=%b rst=%b expected redo=%b flush=%b stall=%b rst=%b",
                     tag, redo, flush, stall, core_reset, e_redo, e_flush, e_stall, e_reset);
        end
    endtask

    function automatic string classify(input logic [NS-1:0] e, input logic j);
        if (e_reset) return "R7";
        if (m_fatal == 1'b0 && e == '0) return "R6";
        if ($countones(e) > 1) return "R5";
        if (j && (e & NS'(3)) != '0) return "R3";
        if ((e & NS'(3)) != '0) return "R4";
        if (e != '0) return "R2";
        return "R8";
    endfunction

    task automatic step(input logic [NS-1:0] e, input logic j, input string tag);
        @(negedge clk);
        stage_err = e;
        ctl_xfer  = j;
        @(posedge clk);
        model_step(e, j);
        #1;
        check_out(tag == "" ? classify(e, j) : tag);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        stage_err = '0;
        ctl_xfer = 1'b0;
        model_reset();
        repeat (2) @(negedge clk);
        check_out("R1");
        rst_n = 1'b1;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin : main
        int seed;
        logic [NS-1:0] e;
        logic j;
        seed = 32'h5eed_c0de;
        void'($urandom(seed));
        model_reset();
        do_reset();
        step('0, 1'b0, "R1");

        // R2: lone errors in later stages, with and without a jump
        step(5'b00100, 1'b0, "R2");
        step(5'b00000, 1'b0, "R6");
        step(5'b01000, 1'b1, "R2");
        step(5'b10000, 1'b0, "R2");
        step(5'b00000, 1'b0, "R6");

        // R3: front-stage errors made moot by a taken jump
        step(5'b00001, 1'b1, "R3");
        step(5'b00010, 1'b1, "R3");
        step(5'b00011, 1'b1, "R3");
        step(5'b00000, 1'b0, "R6");

        // R4: front-stage errors replayed without a jump
        step(5'b00010, 1'b0, "R4");
        step(5'b00000, 1'b0, "R6");
        step(5'b00001, 1'b0, "R4");
        step(5'b00000, 1'b0, "R6");

        // R5: simultaneous errors
        step(5'b11010, 1'b0, "R5");
        step(5'b00000, 1'b0, "R6");
        step(5'b10111, 1'b1, "R5");
        step(5'b00000, 1'b0, "R6");

        // R7: persistent fault in memory stage escalates on third cycle
        step(5'b01000, 1'b0, "R7");
        step(5'b01000, 1'b0, "R7");
        step(5'b01000, 1'b0, "R7");
        // R8: inputs during the reset cycle are ignored
        step(5'b01000, 1'b0, "R8");
        step(5'b01000, 1'b0, "R8");
        step(5'b00000, 1'b0, "R6");

        // R7: a clean cycle breaks the run
        step(5'b00100, 1'b0, "R7");
        step(5'b00100, 1'b0, "R7");
        step(5'b00000, 1'b0, "R7");
        step(5'b00100, 1'b0, "R7");
        step(5'b00100, 1'b0, "R7");
        step(5'b00000, 1'b0, "R7");

        // R7: a jump-masked error still counts toward escalation
        step(5'b00001, 1'b1, "R7");
        step(5'b00001, 1'b1, "R7");
        step(5'b00001, 1'b1, "R7");
        step(5'b00000, 1'b0, "R8");

        // R8: asynchronous reset clears the repeat counts
        step(5'b00010, 1'b0, "R8");
        step(5'b00010, 1'b0, "R8");
        do_reset();
        step(5'b00010, 1'b0, "R8");
        step(5'b00010, 1'b0, "R8");
        step(5'b00000, 1'b0, "R8");

        // mixed random traffic
        for (int n = 0; n < 4000; n++) begin
            e = '0;
            for (int s = 0; s < NS; s++) e[s] = ($urandom_range(0, 4) == 0);
            if ($urandom_range(0, 19) == 0) e = 5'b00100 << $urandom_range(0, 2);
            j = ($urandom_range(0, 2) == 0);
            step(e, j, "");
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule